// File: doc/BRIEF.md
# Gate Driver Power-Up and Protection Supervisor

This block brings up the internal supplies of a gate driver in a fixed order and merges four protection conditions into enables and a fault indication. It receives sampled levels, each qualified by a common valid strobe. These are the regulator supply in millivolts, the reference regulator output and its programmed value, the magnitude of the negative rail and its programmed value, and the die temperature in two's-complement degrees Celsius. Each protection compares its sample against its own pair of hysteresis thresholds. Percentage limits are evaluated with an integer multiply, so no division is needed.

A five-state machine drives the reference-regulator enable, the charge-pump enable and the gate-control enable. The states are LOCKOUT, REF_RAMP, PUMP_RAMP, SETTLE and RUN. Any state moves to LOCKOUT while undervoltage or over-temperature is flagged. LOCKOUT moves to REF_RAMP once both clear. From PUMP_RAMP, SETTLE or RUN the machine falls back to REF_RAMP while the reference monitor is flagged, and REF_RAMP advances to PUMP_RAMP once that monitor clears. SETTLE and RUN fall back to PUMP_RAMP while the negative-rail monitor is flagged, and PUMP_RAMP advances to SETTLE once it clears. SETTLE moves to RUN after a fixed wait derived from the clock frequency.

The protection-active flag and the active-low fault output follow the monitor flags directly. Every flag recovers by itself when its condition clears.

Top module: `drv_supply_supervisor`

## Requirements
- R1: During and right after reset, ref_en, pump_en and gate_en are 0, prot_active is 1 and fault_n is 0.
- R2: The undervoltage flag sets on a valid sample with vreg_mv below 4500 and clears on a valid sample above 4650. A sample at 4500 or at 4650 leaves the flag as it is.
- R3: The reference flag sets when vref_mv*100 < vref_set_mv*75 and clears when vref_mv*100 > vref_set_mv*85. Exactly 75 % or exactly 85 % leaves it unchanged.
- R4: The negative-rail flag sets when vneg_mv*100 < vneg_set_mv*60 and clears when vneg_mv*100 > vneg_set_mv*70. Exactly 60 % or exactly 70 % leaves it unchanged.
- R5: The thermal flag sets when die_temp_c (signed) exceeds 150 and clears when it falls below 120. Readings of 150 or 120 hold the flag. Negative readings count as cool.
- R6: Level inputs presented while smp_valid is 0 change no flag and no output.
- R7: ref_en rises one cycle after the sample that clears both undervoltage and thermal. pump_en rises one cycle after the sample that clears the reference flag. pump_en implies ref_en, and gate_en implies pump_en.
- R8: gate_en rises on the clock edge WAIT_CYC+1 cycles after the sample edge that clears the negative-rail flag, where WAIT_CYC = CLK_HZ/1e6 * WAIT_US.
- R9: If the negative-rail flag sets during the wait, the wait restarts from zero at the next clearing sample.
- R10: Undervoltage or thermal drops all three enables. The reference flag drops gate_en and pump_en but keeps ref_en. The negative-rail flag drops only gate_en. Each takes effect one cycle after the sample.
- R11: prot_active is 1 exactly when any flag is set, updated at the sample edge, and fault_n is its inverse.
- R12: After any flag clears, the sequence resumes by itself without reset and reaches gate_en = 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Qualifies all level inputs for one cycle |
| vreg_mv | input | 16 | Regulator supply level, mV |
| vref_mv | input | 16 | Reference regulator output, mV |
| vref_set_mv | input | 16 | Programmed reference value, mV |
| vneg_mv | input | 16 | Negative rail magnitude, mV |
| vneg_set_mv | input | 16 | Programmed negative rail magnitude, mV |
| die_temp_c | input | 10 | Die temperature, signed degrees C |
| ref_en | output | 1 | Reference regulator enable |
| pump_en | output | 1 | Charge pump enable |
| gate_en | output | 1 | Gate control enable |
| prot_active | output | 1 | Any protection active, to the switch sequencer |
| fault_n | output | 1 | Fault output, 0 means pulled low |

## Verification
The bench drives each monitor exactly onto both of its thresholds and one count past each. A design using the wrong inequality would trip or release one sample early, and the bench would see prot_active toggle when it should hold. It checks which enables each protection removes, so a design that lets the reference monitor cut the reference regulator, or the negative-rail monitor cut the pump, is caught. It measures gate_en to the exact cycle, both on a clean wait and after the rail drops partway through it. A counter that resumes instead of restarting would release the gate early. Stray levels presented without the strobe must leave every output alone.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;
    typedef enum logic [2:0] {
        SUP_LOCKOUT,
        SUP_REF_RAMP,
        SUP_PUMP_RAMP,
        SUP_SETTLE,
        SUP_RUN
    } sup_state_e;
endpackage

// File: rtl/sup_hyst_flag.sv
module sup_hyst_flag #(
    parameter int CW       = 16,
    parameter bit TRIP_LOW = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trip_lvl,
    input  logic [CW-1:0] clear_lvl,
    output logic          active
);
    logic trip_hit;
    logic clear_hit;

    generate
        if (TRIP_LOW) begin : g_trip_low
            assign trip_hit  = level < trip_lvl;
            assign clear_hit = level > clear_lvl;
        end else begin : g_trip_high
            assign trip_hit  = level > trip_lvl;
            assign clear_hit = level < clear_lvl;
        end
    endgenerate

    // Flag comes out of reset set; it only moves on a qualified sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b1;
        end else if (sample) begin
            active <= active ? !clear_hit : trip_hit;
        end
    end
endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
    import drv_sup_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_f,
    input  logic vref_f,
    input  logic vneg_f,
    input  logic therm_f,
    output logic ref_en,
    output logic pump_en,
    output logic gate_en
);
    localparam int CNTW = $clog2(WAIT_CYC + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(WAIT_CYC - 1);

    sup_state_e      st;
    sup_state_e      nxt;
    logic [CNTW-1:0] cnt;
    logic            hard;

    assign hard = uvlo_f || therm_f;

    always_comb begin
        nxt = st;
        unique case (st)
            SUP_LOCKOUT: begin
                if (!hard) nxt = SUP_REF_RAMP;
            end
            SUP_REF_RAMP: begin
                if (hard)         nxt = SUP_LOCKOUT;
                else if (!vref_f) nxt = SUP_PUMP_RAMP;
            end
            SUP_PUMP_RAMP: begin
                if (hard)         nxt = SUP_LOCKOUT;
                else if (vref_f)  nxt = SUP_REF_RAMP;
                else if (!vneg_f) nxt = SUP_SETTLE;
            end
            SUP_SETTLE: begin
                if (hard)             nxt = SUP_LOCKOUT;
                else if (vref_f)      nxt = SUP_REF_RAMP;
                else if (vneg_f)      nxt = SUP_PUMP_RAMP;
                else if (cnt == LAST) nxt = SUP_RUN;
            end
            SUP_RUN: begin
                if (hard)        nxt = SUP_LOCKOUT;
                else if (vref_f) nxt = SUP_REF_RAMP;
                else if (vneg_f) nxt = SUP_PUMP_RAMP;
            end
            default: nxt = SUP_LOCKOUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SUP_LOCKOUT;
        else        st <= nxt;
    end

    // Wait counter runs only while staying in SETTLE; any exit clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt <= '0;
        else if (st == SUP_SETTLE && nxt == SUP_SETTLE) cnt <= cnt + 1'b1;
        else                                          cnt <= '0;
    end

    always_comb begin
        ref_en  = 1'b0;
        pump_en = 1'b0;
        gate_en = 1'b0;
        unique case (st)
            SUP_LOCKOUT:  ;
            SUP_REF_RAMP: ref_en = 1'b1;
            SUP_PUMP_RAMP,
            SUP_SETTLE: begin
                ref_en  = 1'b1;
                pump_en = 1'b1;
            end
            SUP_RUN: begin
                ref_en  = 1'b1;
                pump_en = 1'b1;
                gate_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/drv_supply_supervisor.sv
module drv_supply_supervisor #(
    parameter int unsigned CLK_HZ         = 100_000_000,
    parameter int unsigned WAIT_US        = 100,
    parameter int          LW             = 16,
    parameter int          TW             = 10,
    parameter int unsigned UV_TRIP_MV     = 4500,
    parameter int unsigned UV_CLEAR_MV    = 4650,
    parameter int unsigned REF_TRIP_PCT   = 75,
    parameter int unsigned REF_CLEAR_PCT  = 85,
    parameter int unsigned NEG_TRIP_PCT   = 60,
    parameter int unsigned NEG_CLEAR_PCT  = 70,
    parameter int          HOT_TRIP_C     = 150,
    parameter int          HOT_CLEAR_C    = 120
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [LW-1:0]        vreg_mv,
    input  logic [LW-1:0]        vref_mv,
    input  logic [LW-1:0]        vref_set_mv,
    input  logic [LW-1:0]        vneg_mv,
    input  logic [LW-1:0]        vneg_set_mv,
    input  logic signed [TW-1:0] die_temp_c,
    output logic                 ref_en,
    output logic                 pump_en,
    output logic                 gate_en,
    output logic                 prot_active,
    output logic                 fault_n
);
    localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;
    localparam int          SW       = LW + 7;
    localparam logic [TW-1:0] SIGN_FLIP = {1'b1, {(TW-1){1'b0}}};
    localparam logic [TW-1:0] HOT_TRIP_B  = TW'(HOT_TRIP_C) ^ SIGN_FLIP;
    localparam logic [TW-1:0] HOT_CLEAR_B = TW'(HOT_CLEAR_C) ^ SIGN_FLIP;

    logic          uvlo_f, vref_f, vneg_f, therm_f;
    logic [SW-1:0] vref_x100, vref_lo, vref_hi;
    logic [SW-1:0] vneg_x100, vneg_lo, vneg_hi;
    logic [TW-1:0] temp_b;

    // Percent compare: level*100 against programmed*pct, no division.
    assign vref_x100 = {7'b0, vref_mv}     * SW'(100);
    assign vref_lo   = {7'b0, vref_set_mv} * SW'(REF_TRIP_PCT);
    assign vref_hi   = {7'b0, vref_set_mv} * SW'(REF_CLEAR_PCT);
    assign vneg_x100 = {7'b0, vneg_mv}     * SW'(100);
    assign vneg_lo   = {7'b0, vneg_set_mv} * SW'(NEG_TRIP_PCT);
    assign vneg_hi   = {7'b0, vneg_set_mv} * SW'(NEG_CLEAR_PCT);

    // Offset-binary view of the signed temperature so unsigned compare works.
    assign temp_b = die_temp_c ^ SIGN_FLIP;

    sup_hyst_flag #(.CW(LW), .TRIP_LOW(1'b1)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .sample(smp_valid), .level(vreg_mv),
        .trip_lvl(LW'(UV_TRIP_MV)), .clear_lvl(LW'(UV_CLEAR_MV)), .active(uvlo_f)
    );

    sup_hyst_flag #(.CW(SW), .TRIP_LOW(1'b1)) u_vref (
        .clk(clk), .rst_n(rst_n), .sample(smp_valid), .level(vref_x100),
        .trip_lvl(vref_lo), .clear_lvl(vref_hi), .active(vref_f)
    );

    sup_hyst_flag #(.CW(SW), .TRIP_LOW(1'b1)) u_vneg (
        .clk(clk), .rst_n(rst_n), .sample(smp_valid), .level(vneg_x100),
        .trip_lvl(vneg_lo), .clear_lvl(vneg_hi), .active(vneg_f)
    );

    sup_hyst_flag #(.CW(TW), .TRIP_LOW(1'b0)) u_therm (
        .clk(clk), .rst_n(rst_n), .sample(smp_valid), .level(temp_b),
        .trip_lvl(HOT_TRIP_B), .clear_lvl(HOT_CLEAR_B), .active(therm_f)
    );

    sup_seq_fsm #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .uvlo_f(uvlo_f), .vref_f(vref_f), .vneg_f(vneg_f), .therm_f(therm_f),
        .ref_en(ref_en), .pump_en(pump_en), .gate_en(gate_en)
    );

    assign prot_active = uvlo_f | vref_f | vneg_f | therm_f;
    assign fault_n     = ~prot_active;
endmodule

// File: rtl/drv_sup_checker.sv
module drv_sup_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic uvlo_f,
    input logic therm_f,
    input logic vref_f,
    input logic ref_en,
    input logic pump_en,
    input logic gate_en,
    input logic prot_active,
    input logic fault_n
);
    a_r7_pump_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en |-> ref_en);

    a_r7_gate_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> pump_en);

    a_r11_fault_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |=> !gate_en);

    a_r10_hard_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_f || therm_f) |=> (!ref_en && !pump_en && !gate_en));

    a_r10_ref_fault_pump_off: assert property (@(posedge clk) disable iff (!rst_n)
        vref_f |=> !pump_en);

    a_r6_no_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(prot_active));

    a_r8_gate_entry_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(pump_en) && !$past(prot_active)));
endmodule

bind drv_supply_supervisor drv_sup_checker u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .uvlo_f(uvlo_f), .therm_f(therm_f), .vref_f(vref_f),
    .ref_en(ref_en), .pump_en(pump_en), .gate_en(gate_en),
    .prot_active(prot_active), .fault_n(fault_n)
);

// File: tb/drv_supply_supervisor_tb_top.sv
module drv_supply_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_CLK_HZ = 1_000_000;
    localparam int unsigned TB_WAIT_US = 100;
    localparam int WAIT = (TB_CLK_HZ / 1_000_000) * TB_WAIT_US;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [15:0]       vreg_mv = '0;
    logic [15:0]       vref_mv = '0;
    logic [15:0]       vref_set_mv = 16'd5000;
    logic [15:0]       vneg_mv = '0;
    logic [15:0]       vneg_set_mv = 16'd5000;
    logic signed [9:0] die_temp_c = '0;
    logic ref_en, pump_en, gate_en, prot_active, fault_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drv_supply_supervisor #(.CLK_HZ(TB_CLK_HZ), .WAIT_US(TB_WAIT_US)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .vreg_mv(vreg_mv), .vref_mv(vref_mv), .vref_set_mv(vref_set_mv),
        .vneg_mv(vneg_mv), .vneg_set_mv(vneg_set_mv), .die_temp_c(die_temp_c),
        .ref_en(ref_en), .pump_en(pump_en), .gate_en(gate_en),
        .prot_active(prot_active), .fault_n(fault_n)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One qualified sample; returns at the negedge after the sampling edge.
    task automatic put(input int vg, input int vr, input int vn, input int tc);
        @(negedge clk);
        vreg_mv = 16'(vg); vref_mv = 16'(vr); vneg_mv = 16'(vn);
        die_temp_c = 10'(tc);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wait_gate(input string what);
        for (int i = 0; i < WAIT + 20; i++) begin
            if (gate_en) break;
            @(negedge clk);
        end
        chk(gate_en, 1'b1, what);
    endtask

    task automatic t_reset;
        step(2);
        chk(ref_en, 1'b0, "R1 ref_en in reset");
        chk(gate_en, 1'b0, "R1 gate_en in reset");
        chk(fault_n, 1'b0, "R1 fault_n in reset");
        rst_n = 1'b1;
        step(1);
        chk(pump_en, 1'b0, "R1 pump_en after reset");
        chk(prot_active, 1'b1, "R1 prot_active after reset");
    endtask

    task automatic t_startup;
        put(5000, 0, 0, 25);
        chk(prot_active, 1'b1, "R11 prot_active with reference low");
        step(1);
        chk(ref_en, 1'b1, "R7 ref_en after lockout clears");
        chk(pump_en, 1'b0, "R7 pump_en waits for reference");
        put(5000, 5000, 0, 25);
        step(1);
        chk(pump_en, 1'b1, "R7 pump_en after reference ok");
        chk(gate_en, 1'b0, "R7 gate_en waits for rail");
        put(5000, 5000, 5000, 25);
        chk(prot_active, 1'b0, "R11 prot_active clear");
        chk(fault_n, 1'b1, "R11 fault_n released");
        step(WAIT);
        chk(gate_en, 1'b0, "R8 gate_en one cycle before wait ends");
        step(1);
        chk(gate_en, 1'b1, "R8 gate_en at end of wait");
    endtask

    task automatic t_uvlo;
        put(4500, 5000, 5000, 25);
        step(1);
        chk(prot_active, 1'b0, "R2 4500 mV does not trip");
        chk(gate_en, 1'b1, "R2 gate stays on at 4500 mV");
        put(4499, 5000, 5000, 25);
        chk(prot_active, 1'b1, "R2 4499 mV trips");
        chk(fault_n, 1'b0, "R11 fault_n on undervoltage");
        step(1);
        chk(ref_en, 1'b0, "R10 undervoltage drops ref_en");
        chk(pump_en, 1'b0, "R10 undervoltage drops pump_en");
        chk(gate_en, 1'b0, "R10 undervoltage drops gate_en");
        put(4650, 5000, 5000, 25);
        chk(prot_active, 1'b1, "R2 4650 mV holds");
        put(4651, 5000, 5000, 25);
        chk(prot_active, 1'b0, "R2 4651 mV releases");
        step(1);
        chk(ref_en, 1'b1, "R12 ref_en resumes");
        chk(pump_en, 1'b0, "R7 pump_en one stage later");
        step(1);
        chk(pump_en, 1'b1, "R12 pump_en resumes");
        wait_gate("R12 gate_en resumes after undervoltage");
    endtask

    task automatic t_ref_mon;
        @(negedge clk);
        vref_set_mv = 16'd4000;
        put(5000, 3000, 5000, 25);
        step(1);
        chk(prot_active, 1'b0, "R3 exactly 75 pct holds");
        put(5000, 2999, 5000, 25);
        chk(prot_active, 1'b1, "R3 below 75 pct trips");
        step(1);
        chk(gate_en, 1'b0, "R10 reference fault drops gate_en");
        chk(pump_en, 1'b0, "R10 reference fault drops pump_en");
        chk(ref_en, 1'b1, "R10 reference fault keeps ref_en");
        put(5000, 3400, 5000, 25);
        chk(prot_active, 1'b1, "R3 exactly 85 pct holds");
        put(5000, 3401, 5000, 25);
        chk(prot_active, 1'b0, "R3 above 85 pct releases");
        step(1);
        chk(pump_en, 1'b1, "R12 pump_en back after reference");
        wait_gate("R12 gate_en back after reference");
    endtask

    task automatic t_neg_mon;
        put(5000, 3401, 3000, 25);
        step(1);
        chk(prot_active, 1'b0, "R4 exactly 60 pct holds");
        put(5000, 3401, 2999, 25);
        chk(prot_active, 1'b1, "R4 below 60 pct trips");
        step(1);
        chk(gate_en, 1'b0, "R10 rail fault drops gate_en");
        chk(pump_en, 1'b1, "R10 rail fault keeps pump_en");
        chk(ref_en, 1'b1, "R10 rail fault keeps ref_en");
        put(5000, 3401, 3500, 25);
        chk(prot_active, 1'b1, "R4 exactly 70 pct holds");
        put(5000, 3401, 3501, 25);
        chk(prot_active, 1'b0, "R4 above 70 pct releases");
        step(WAIT / 2);
        put(5000, 3401, 2999, 25);
        step(1);
        chk(gate_en, 1'b0, "R9 gate_en off after mid-wait loss");
        put(5000, 3401, 3501, 25);
        step(WAIT);
        chk(gate_en, 1'b0, "R9 wait restarted from zero");
        step(1);
        chk(gate_en, 1'b1, "R9 gate_en after full restarted wait");
    endtask

    task automatic t_thermal;
        put(5000, 3401, 3501, 150);
        step(1);
        chk(prot_active, 1'b0, "R5 150 C does not trip");
        put(5000, 3401, 3501, 151);
        chk(prot_active, 1'b1, "R5 151 C trips");
        step(1);
        chk(ref_en, 1'b0, "R10 thermal drops ref_en");
        chk(gate_en, 1'b0, "R10 thermal drops gate_en");
        put(5000, 3401, 3501, 120);
        chk(prot_active, 1'b1, "R5 120 C holds");
        put(5000, 3401, 3501, 119);
        chk(prot_active, 1'b0, "R5 119 C releases");
        wait_gate("R12 gate_en back after thermal");
        put(5000, 3401, 3501, -40);
        step(1);
        chk(prot_active, 1'b0, "R5 -40 C is cool");
        chk(gate_en, 1'b1, "R5 gate_en at -40 C");
    endtask

    task automatic t_no_valid;
        @(negedge clk);
        vreg_mv = 16'd0; vref_mv = 16'd0; vneg_mv = 16'd0;
        die_temp_c = 10'sd200;
        step(5);
        chk(prot_active, 1'b0, "R6 bad levels without strobe ignored");
        chk(gate_en, 1'b1, "R6 gate_en unaffected without strobe");
        chk(ref_en, 1'b1, "R6 ref_en unaffected without strobe");
    endtask

    initial begin
        t_reset();
        t_startup();
        t_uvlo();
        t_ref_mon();
        t_neg_mon();
        t_thermal();
        t_no_valid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule